// File: doc/BRIEF.md
# Gray-Pointer Programmable Delay FIFO

This block is a 128-entry, 8-bit wide dual-clock buffer used as a fixed-latency delay line. Bytes enter on the write clock and leave on the read clock. Both the write and the read address step through a 7-bit reflected Gray sequence, so each address crosses between the clock domains through a plain two-flop synchronizer. The read address is not cleared to zero. Instead it is preloaded from a programmed delay value, and the distance between the two pointers sets the latency from input to output.

The delay value is held in a read-clock register. A host changes it with a one-cycle write strobe. Each accepted write reloads both pointers: the read pointer takes the new value at once, and the write pointer is forced to zero through a synchronized toggle. Only Gray codes with an even number of ones are accepted, so the delay moves in steps of two positions. Any other value is refused and recorded in a sticky flag.

In the read domain the block compares the synchronized write pointer with the read pointer. When the two meet (overrun or underrun), it raises a one-cycle collision pulse and a sticky bit. When the auto-reload bit is set, a collision also reloads both pointers to the programmed offset.

Top module: `gdly_fifo`

## Requirements
- R1: Each pointer steps through the 7-bit reflected Gray sequence (0x00, 0x01, 0x03, 0x02, 0x06, …, 0x41, 0x40, then back to 0x00). It advances by one position, changing exactly one bit, on every clock where its strobe is high. It holds its value when the strobe is low.
- R2: After reset, `wr_addr` = 0x00, `rd_addr` = 0x60, `delay_q` = 0x60, and `illegal_seen`, `coll_seen` and `coll_pulse` are 0.
- R3: A `cfg_we` strobe whose `cfg_delay` has even parity is legal. It updates `delay_q` and loads `rd_addr` with that value on the next read-clock edge. It also forces `wr_addr` to 0x00 on the third write-clock edge after that edge, and `wr_addr` keeps its old value on the two edges before.
- R4: A `cfg_we` strobe whose `cfg_delay` has odd parity leaves `delay_q` and `rd_addr` unchanged and sets `illegal_seen` to 1. The flag stays 1 until reset.
- R5: A byte written at Gray position p is returned when the read pointer reaches p. With both strobes high on every cycle after a reload to delay value d, the byte written by the k-th write strobe is returned by read strobe k + 128 − i, where i is the sequence index of d (0x60 gives 64, 0x0C gives 120).
- R6: `coll_pulse` is high for exactly one read clock when the synchronized write pointer becomes equal to the read pointer. `coll_seen` then stays 1 until reset. This happens whether or not auto-reload is set. Equality is ignored for 8 read clocks after every reload.
- R7: With `cfg_auto` = 0, a collision leaves both pointers running: they are not reloaded.
- R8: With `cfg_auto` = 1, every collision reloads `rd_addr` to `delay_q` and forces `wr_addr` to 0x00 through the same path a legal delay write uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write byte strobe |
| wr_data | input | 8 | Byte to store |
| rd_clk | input | 1 | Read-side clock, also clocks the delay register |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_en | input | 1 | Read byte strobe |
| rd_data | output | 8 | Byte read, valid after the edge that took `rd_en` |
| cfg_we | input | 1 | Delay register write strobe (read clock) |
| cfg_delay | input | 7 | Gray value for the read-pointer preload |
| cfg_auto | input | 1 | 1 = reload the pointers after every collision |
| delay_q | output | 7 | Currently programmed delay value |
| illegal_seen | output | 1 | Sticky: an odd-parity delay write was refused |
| coll_pulse | output | 1 | One-cycle collision indication (read clock) |
| coll_seen | output | 1 | Sticky collision flag |
| wr_addr | output | 7 | Current write pointer (Gray) |
| rd_addr | output | 7 | Current read pointer (Gray) |

## Verification
The bench walks the read pointer through the full Gray sequence and across the wrap from 0x40 to 0x00. A design with a wrong successor table would go out of step there. It sends an odd-parity delay write and checks that neither the register nor the pointer moves. A design that skipped the parity test would jump to an illegal offset. It times the write-pointer clear edge by edge after a delay write, then streams data at two offsets and checks every returned byte against the latency formula, which exposes an off-by-one pointer or a wrong preload. Finally, it fills the buffer with writes only, with and without auto-reload. It counts the collision pulses and watches how far the write pointer gets: a design that always reloads, never reloads or repeats its pulse gives the wrong count or the wrong top address.

// File: rtl/gdly_pkg.sv
`timescale 1ns/1ps
package gdly_pkg;
  localparam int unsigned GDLY_AW = 7;
  localparam int unsigned GDLY_DW = 8;

  // successor of a w-bit reflected Gray value (upper bits of g must be zero)
  function automatic logic [31:0] gray_next(input logic [31:0] g, input int unsigned w);
    logic [31:0] b;
    logic [31:0] m;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    m = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
    b = (b + 32'd1) & m;
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/gdly_sync.sv
`timescale 1ns/1ps
module gdly_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gdly_gray_ptr.sv
`timescale 1ns/1ps
module gdly_gray_ptr #(
  parameter int unsigned AW      = 7,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = AW'(gdly_pkg::gray_next(32'(ptr_q), AW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= AW'(RST_VAL);
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R1
  gray_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> $countones(ptr_q ^ $past(ptr_q)) == 1);
  // R1
  gray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load |=> $stable(ptr_q));
endmodule

// File: rtl/gdly_ram.sv
`timescale 1ns/1ps
module gdly_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gdly_fifo.sv
`timescale 1ns/1ps
module gdly_fifo #(
  parameter int unsigned AW          = gdly_pkg::GDLY_AW,
  parameter int unsigned DW          = gdly_pkg::GDLY_DW,
  parameter int unsigned DELAY_RST   = 'h60,
  parameter int unsigned BLANK       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_delay,
  input  logic          cfg_auto,
  output logic [AW-1:0] delay_q,
  output logic          illegal_seen,
  output logic          coll_pulse,
  output logic          coll_seen,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  localparam int unsigned BW = $clog2(BLANK + 1);

  // reset release synchronizers
  logic wr_rst_s, rd_rst_s;
  gdly_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(wr_rst_s));
  gdly_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(rd_rst_s));

  // ---------------- read / host domain ----------------
  logic [AW-1:0] rptr_g, wptr_rs, dly_q, dly_d;
  logic          ill_q, ill_d, cs_q, cs_d, eq_q, eq_now, coll;
  logic          legal_we, rd_reload, tgl_q, tgl_d;
  logic [BW-1:0] blk_q, blk_d;

  always_comb begin
    legal_we  = cfg_we && !(^cfg_delay);
    eq_now    = (wptr_rs == rptr_g) && (blk_q == '0);
    coll      = eq_now && !eq_q;
    rd_reload = legal_we || (coll && cfg_auto);
    dly_d     = legal_we ? cfg_delay : dly_q;
    ill_d     = ill_q || (cfg_we && (^cfg_delay));
    cs_d      = cs_q || coll;
    tgl_d     = tgl_q ^ rd_reload;
    if (rd_reload)         blk_d = BW'(BLANK);
    else if (blk_q != '0)  blk_d = blk_q - BW'(1);
    else                   blk_d = blk_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_s) begin
    if (!rd_rst_s) begin
      dly_q <= AW'(DELAY_RST);
      ill_q <= 1'b0;
      cs_q  <= 1'b0;
      eq_q  <= 1'b0;
      tgl_q <= 1'b0;
      blk_q <= BW'(BLANK);
    end else begin
      dly_q <= dly_d;
      ill_q <= ill_d;
      cs_q  <= cs_d;
      eq_q  <= eq_now;
      tgl_q <= tgl_d;
      blk_q <= blk_d;
    end
  end

  gdly_gray_ptr #(.AW(AW), .RST_VAL(DELAY_RST)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_s), .step(rd_en), .load(rd_reload),
    .load_val(dly_d), .ptr(rptr_g));

  // ---------------- write domain ----------------
  logic [AW-1:0] wptr_g;
  logic          tgl_ws, tgl_ws_q, wr_reload;

  gdly_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl (
    .clk(wr_clk), .rst_n(wr_rst_s), .d(tgl_q), .q(tgl_ws));

  always_ff @(posedge wr_clk or negedge wr_rst_s) begin
    if (!wr_rst_s) tgl_ws_q <= 1'b0;
    else           tgl_ws_q <= tgl_ws;
  end

  always_comb wr_reload = tgl_ws ^ tgl_ws_q;

  gdly_gray_ptr #(.AW(AW), .RST_VAL(0)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_s), .step(wr_en), .load(wr_reload),
    .load_val('0), .ptr(wptr_g));

  gdly_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rd_clk), .rst_n(rd_rst_s), .d(wptr_g), .q(wptr_rs));

  gdly_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(wr_en), .waddr(wptr_g), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_en), .raddr(rptr_g), .rdata(rd_data));

  assign delay_q      = dly_q;
  assign illegal_seen = ill_q;
  assign coll_pulse   = coll;
  assign coll_seen    = cs_q;
  assign wr_addr      = wptr_g;
  assign rd_addr      = rptr_g;

  // R3
  legal_load_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    cfg_we && !(^cfg_delay) |=> (rptr_g == $past(cfg_delay)) && (dly_q == $past(cfg_delay)));
  // R4
  illegal_keep_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    cfg_we && (^cfg_delay) |=> (dly_q == $past(dly_q)) && ill_q);
  // R4
  delay_parity_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    !(^dly_q));
  // R6
  coll_single_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    coll |=> !coll && cs_q);
  // R7
  no_auto_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    coll && !cfg_auto && !cfg_we && !rd_en |=> $stable(rptr_g));
  // R8
  auto_reload_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    coll && cfg_auto && !cfg_we |=> rptr_g == $past(dly_q));
  // R3
  wr_clear_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    wr_reload |=> wptr_g == '0);
endmodule

// File: tb/gdly_fifo_test.sv
`timescale 1ns/1ps
module gdly_fifo_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, wr_en, rd_en, cfg_we, cfg_auto;
  logic [7:0] wr_data, rd_data;
  logic [6:0] cfg_delay, delay_q, wr_addr, rd_addr;
  logic       illegal_seen, coll_pulse, coll_seen;

  gdly_fifo uut (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_delay(cfg_delay), .cfg_auto(cfg_auto),
    .delay_q(delay_q), .illegal_seen(illegal_seen), .coll_pulse(coll_pulse),
    .coll_seen(coll_seen), .wr_addr(wr_addr), .rd_addr(rd_addr));

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  int  lag = 0;
  int  rd_cnt = 0;
  bit  stream_on = 0;
  bit  track = 0;
  int  max_widx = 0;
  int  pulse_cnt = 0;
  logic rd_fired = 1'b0;

  function automatic logic [6:0] b2g(input int i);
    logic [6:0] b;
    b = 7'(i % 128);
    return b ^ (b >> 1);
  endfunction

  function automatic int g2i(input logic [6:0] g);
    for (int i = 0; i < 128; i++) if (b2g(i) == g) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; cfg_we = 0; cfg_auto = 0;
    wr_data = '0; cfg_delay = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic cfg_write(input logic [6:0] v);
    cfg_we = 1'b1; cfg_delay = v;
    tick();
    cfg_we = 1'b0;
  endtask

  // driver: pushes every written byte into the scoreboard queue
  task automatic stream(input int n, input int l, input int seed);
    exp_q.delete();
    rd_cnt = 0; lag = l; stream_on = 1;
    for (int i = 0; i < n; i++) begin
      wr_en = 1; rd_en = 1;
      wr_data = 8'((i * 37 + seed) & 8'hff);
      exp_q.push_back(wr_data);
      tick();
    end
    wr_en = 0; rd_en = 0;
    tick();
    stream_on = 0;
  endtask

  task automatic write_only(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = 8'(i);
      tick();
    end
    wr_en = 0;
  endtask

  always @(posedge clk) rd_fired <= rd_en;

  // monitor: pops expected bytes and compares (R5), counts pulses
  always @(negedge clk) begin
    if (coll_pulse) pulse_cnt++;
    if (track && g2i(wr_addr) > max_widx) max_widx = g2i(wr_addr);
    if (rd_fired && stream_on) begin
      rd_cnt++;
      if (rd_cnt > lag) begin
        if (exp_q.size() == 0) check(0, "R5 queue empty", 0, 1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R5 data", rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    // reset state
    do_reset();
    check(wr_addr == 7'h00, "R2 wr_addr", wr_addr, 0);
    check(rd_addr == 7'h60, "R2 rd_addr", rd_addr, 'h60);
    check(delay_q == 7'h60, "R2 delay_q", delay_q, 'h60);
    check(illegal_seen == 0 && coll_seen == 0 && coll_pulse == 0, "R2 flags",
          {illegal_seen, coll_seen, coll_pulse}, 0);

    // full Gray walk of the read pointer, writes idle
    pulse_cnt = 0;
    rd_en = 1;
    for (int k = 1; k <= 130; k++) begin
      tick();
      check(rd_addr == b2g(64 + k), "R1 sequence", rd_addr, b2g(64 + k));
    end
    rd_en = 0;
    tick();
    check(rd_addr == b2g(66), "R1 hold", rd_addr, b2g(66));
    check(wr_addr == 7'h00, "R1 write idle", wr_addr, 0);
    check(pulse_cnt == 1, "R6 underrun pulse count", pulse_cnt, 1);
    check(coll_seen == 1, "R6 sticky", coll_seen, 1);
    check(rd_addr == b2g(66), "R7 no reload", rd_addr, b2g(66));

    // illegal then legal delay writes
    do_reset();
    rd_en = 1; repeat (5) tick(); rd_en = 0;
    write_only(10);
    tick();
    cfg_write(7'h07);
    check(delay_q == 7'h60, "R4 delay kept", delay_q, 'h60);
    check(rd_addr == b2g(69), "R4 rd_addr kept", rd_addr, b2g(69));
    check(illegal_seen == 1, "R4 flag", illegal_seen, 1);
    tick();
    check(wr_addr == b2g(10), "R4 wr_addr kept", wr_addr, b2g(10));
    cfg_write(7'h0C);
    check(rd_addr == 7'h0C, "R3 rd load", rd_addr, 'h0C);
    check(delay_q == 7'h0C, "R3 delay_q", delay_q, 'h0C);
    tick();
    check(wr_addr == b2g(10), "R3 wr edge1", wr_addr, b2g(10));
    tick();
    check(wr_addr == b2g(10), "R3 wr edge2", wr_addr, b2g(10));
    tick();
    check(wr_addr == 7'h00, "R3 wr edge3", wr_addr, 0);
    check(illegal_seen == 1, "R4 flag sticky", illegal_seen, 1);

    // data latency at two offsets
    repeat (10) tick();
    p0 = pulse_cnt;
    stream(250, 120, 5);
    check(exp_q.size() == 120, "R5 residue 0x0C", exp_q.size(), 120);
    cfg_write(7'h60);
    repeat (10) tick();
    stream(200, 64, 91);
    check(exp_q.size() == 64, "R5 residue 0x60", exp_q.size(), 64);
    check(pulse_cnt == p0, "R6 no pulse while streaming", pulse_cnt, p0);

    // overrun without auto-reload
    do_reset();
    pulse_cnt = 0; track = 1; max_widx = 0;
    write_only(100);
    repeat (4) tick();
    check(pulse_cnt == 1, "R6 overrun pulse count", pulse_cnt, 1);
    check(coll_seen == 1, "R6 sticky overrun", coll_seen, 1);
    check(wr_addr == b2g(100), "R7 wr not reloaded", wr_addr, b2g(100));
    check(rd_addr == 7'h60, "R7 rd unchanged", rd_addr, 'h60);

    // overrun with auto-reload
    do_reset();
    cfg_auto = 1;
    pulse_cnt = 0; max_widx = 0;
    write_only(200);
    repeat (4) tick();
    check(pulse_cnt >= 2, "R8 repeated collisions", pulse_cnt, 2);
    check(max_widx < 80, "R8 wr reloaded", max_widx, 79);
    check(rd_addr == 7'h60, "R8 rd reload value", rd_addr, 'h60);
    track = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule